// File: doc/BRIEF.md
# Pad Interrupt Router with Glitch Filter

This block watches a wide bus of chip pad inputs and steers any one of them onto each of eight interrupt outputs. Every channel has its own pad selection, trigger style (level or edge), polarity and glitch filter. The outputs are always active-high. A level channel drives a level. An edge channel drives a single-cycle pulse. Low-active and falling-edge sources are therefore turned into the high-level or rising-pulse form that a downstream interrupt controller expects.

Software configures the block through a small word-addressed register port. Writes take effect on the next clock edge. Read data is registered and appears one cycle after the address is presented. Masking, acknowledgement and the choice of which channel serves which pad are left to the downstream controller and to software.

Top module: `pad_irq_router`

## Requirements
- R1: After reset all four configuration registers read zero and `irq_out` is all zeros.
- R2: Register map (byte offsets):
  - 0x00: trigger control. Bit x set makes channel x edge-triggered; clear means level. Bit 16+x set makes channel x low-active or falling-edge.
  - 0x04: pad select for channels 0 to 3.
  - 0x08: pad select for channels 4 to 7.
  - 0x0C: filter control, a 4-bit field per channel at bits [4x+3:4x].
  - Each pad select is an 8-bit field at bits [(x mod 4)*8+7:(x mod 4)*8].
  - Written values read back on `reg_rdata` one cycle after the address is presented.
- R3: Write data for unused bits of the trigger register (bits 8 to 15 and 24 to 31) is discarded, and those bits read zero. Offsets other than the four above ignore writes and read zero.
- R4: In level mode with high polarity, `irq_out[x]` follows the selected pad. A pad change sampled at rising edge E1 shows on `irq_out` at edge E(3+L). L is 1 when the channel's filter field is 0, and 4 times the field value otherwise.
- R5: In level mode with low polarity, `irq_out[x]` is the inverse of the selected pad, with the same latency as R4.
- R6: In edge mode with rising polarity, a rising pad edge produces exactly one cycle of `irq_out[x]` high, at edge E(3+L).
- R7: In edge mode with falling polarity, a falling pad edge produces exactly one cycle high at E(3+L), and a rising pad edge produces none.
- R8: A pad select at or above the pad count makes the channel's input read as zero, whatever the pad bus carries.
- R9: With a non-zero filter value N, the polarity-corrected input must hold a new value for 4N consecutive cycles before the output takes it. A shorter excursion is discarded entirely.
- R10: Channels are independent. One pad may feed several channels with different settings, and the highest pad index is selectable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | 8 | Active-high interrupt per channel |

## Verification
The bench targets the exact edge on which each output changes. A design with an extra or missing pipeline stage would shift that edge and miss it. Two filter excursions are used: one a cycle short of the window and one exactly the window. An off-by-one counter either lets the short glitch through or swallows the exact one. The bench also checks the following:
- A falling-edge channel gives no pulse on a rise. A polarity error would fire on the wrong transition.
- An out-of-range pad select stays quiet while every pad is high. An unguarded index would pick up stray bits.
- Trigger-register readback is masked. A design storing all 32 bits would echo the unused ones.

// File: rtl/pad_irq_pkg.sv
package pad_irq_pkg;
  localparam int NUM_CH     = 8;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 8;
  localparam int FLT_W      = 4;
  localparam int REG_ADDR_W = 8;

  localparam logic [REG_ADDR_W-1:0] OFS_TRIG = 8'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_SELA = 8'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_SELB = 8'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_FILT = 8'h0C;

  // Edge bits in [7:0], polarity bits in [23:16]
  localparam logic [DATA_W-1:0] TRIG_MASK = 32'h00FF_00FF;

  typedef struct packed {
    logic             edge_mode;
    logic             active_low;
    logic [SEL_W-1:0] pad_sel;
    logic [FLT_W-1:0] filt;
  } chan_cfg_t;
endpackage

// File: rtl/pad_irq_regs.sv
module pad_irq_regs
  import pad_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output chan_cfg_t [NUM_CH-1:0] cfg
);
  logic [DATA_W-1:0] trig_q, sela_q, selb_q, filt_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      sela_q <= '0;
      selb_q <= '0;
      filt_q <= '0;
    end else if (we) begin
      case (addr)
        OFS_TRIG: trig_q <= wdata & TRIG_MASK;
        OFS_SELA: sela_q <= wdata;
        OFS_SELB: selb_q <= wdata;
        OFS_FILT: filt_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (addr)
        OFS_TRIG: rdata_q <= trig_q;
        OFS_SELA: rdata_q <= sela_q;
        OFS_SELB: rdata_q <= selb_q;
        OFS_FILT: rdata_q <= filt_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      cfg[ch].edge_mode  = trig_q[ch];
      cfg[ch].active_low = trig_q[16+ch];
      cfg[ch].pad_sel    = (ch < 4) ? sela_q[(ch%4)*SEL_W +: SEL_W]
                                    : selb_q[(ch%4)*SEL_W +: SEL_W];
      cfg[ch].filt       = filt_q[ch*FLT_W +: FLT_W];
    end
  end

  // R3
  trig_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == OFS_TRIG) |-> ((rdata & ~TRIG_MASK) == '0));

  // R3
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) != OFS_TRIG && $past(addr) != OFS_SELA &&
     $past(addr) != OFS_SELB && $past(addr) != OFS_FILT) |-> (rdata == '0));
endmodule

// File: rtl/pad_irq_filter.sv
module pad_irq_filter #(
  parameter int FLT_W = 4,
  parameter int UNIT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [FLT_W-1:0] nsel,
  output logic             dout
);
  localparam int MAX_LEN = ((1 << FLT_W) - 1) * UNIT;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic             q;

  // A zero setting degenerates to a one-sample window (bypass)
  assign lim = (nsel == '0) ? CNT_W'(1) : CNT_W'(nsel) * CNT_W'(UNIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= 1'b0;
      cnt_q <= '0;
    end else if (din == q) begin
      cnt_q <= '0;
    end else if (cnt_q >= lim - 1'b1) begin
      q     <= din;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout = q;

  // R9
  filt_takes_input_chk: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> ($past(din) == q));
endmodule

// File: rtl/pad_irq_chan.sv
module pad_irq_chan
  import pad_irq_pkg::*;
#(
  parameter int NUM_PADS    = 128,
  parameter int SYNC_STAGES = 2,
  parameter int FLT_UNIT    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pads,
  input  chan_cfg_t           cfg,
  output logic                irq
);
  localparam int                 EXT     = 1 << SEL_W;
  localparam logic [SEL_W:0]     PAD_LIM = (SEL_W+1)'(NUM_PADS);

  logic [EXT-1:0]         pad_ext;
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pol;
  logic                   filt;
  logic                   filt_d;
  logic                   irq_q;

  // Zero extension makes any select beyond the pad count read as 0
  assign pad_ext = EXT'(pads);
  assign raw     = pad_ext[cfg.pad_sel];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign pol = sync_q[SYNC_STAGES-1] ^ cfg.active_low;

  pad_irq_filter #(
    .FLT_W (FLT_W),
    .UNIT  (FLT_UNIT)
  ) i_filter (
    .clk  (clk),
    .rst  (rst),
    .din  (pol),
    .nsel (cfg.filt),
    .dout (filt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_d <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      filt_d <= filt;
      irq_q  <= cfg.edge_mode ? (filt & ~filt_d) : filt;
    end
  end

  assign irq = irq_q;

  // R8
  bad_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cfg.pad_sel} >= PAD_LIM) |=> !sync_q[0]);

  // R6
  edge_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && cfg.edge_mode) |=> (!irq_q || !cfg.edge_mode));
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import pad_irq_pkg::*;
#(
  parameter int NUM_PADS    = 128,
  parameter int SYNC_STAGES = 2,
  parameter int FLT_UNIT    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PADS-1:0]   pad_in,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_CH-1:0]     irq_out
);
  chan_cfg_t [NUM_CH-1:0] cfg;
  logic      [NUM_CH-1:0] irq_w;

  pad_irq_regs i_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pad_irq_chan #(
      .NUM_PADS    (NUM_PADS),
      .SYNC_STAGES (SYNC_STAGES),
      .FLT_UNIT    (FLT_UNIT)
    ) i_chan (
      .clk  (clk),
      .rst  (rst),
      .pads (pad_in),
      .cfg  (cfg[ch]),
      .irq  (irq_w[ch])
    );
  end

  assign irq_out = irq_w;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_out == '0));
endmodule

// File: tb/test_pad_irq_router.sv
module test_pad_irq_router;
  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pad_in = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [7:0]    irq_out;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int       at;
    logic [7:0] mask;
    logic [7:0] val;
    string    tag;
  } exp_t;
  exp_t sbq[$];

  pad_irq_router #(.NUM_PADS(NP)) i_pad_irq_router (
    .clk(clk), .rst(rst), .pad_in(pad_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_at(int at, logic [7:0] mask, logic [7:0] val, string tag);
    exp_t e;
    e.at = at; e.mask = mask; e.val = val; e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor: compares irq_out against queued items at their cycle
  always @(negedge clk) begin
    exp_t e;
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      e = sbq.pop_front();
      tests++;
      if (e.at < cyc) begin
        fails++;
        $display("FAIL %s: check missed at %0d (actual cycle %0d expected)", e.tag, cyc, e.at);
      end else if ((irq_out & e.mask) !== (e.val & e.mask)) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", e.tag, irq_out & e.mask, e.val & e.mask);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int k;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_out after reset", {24'h0, irq_out}, 32'h0);
    rd_chk(8'h00, 32'h0, "R1 trig reset");
    rd_chk(8'h04, 32'h0, "R1 sela reset");
    rd_chk(8'h08, 32'h0, "R1 selb reset");
    rd_chk(8'h0C, 32'h0, "R1 filt reset");

    // R2 / R3 register behaviour
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h00FF_00FF, "R3 trig unused bits");
    wr(8'h04, 32'h0403_0201);
    rd_chk(8'h04, 32'h0403_0201, "R2 sela readback");
    wr(8'h0C, 32'hFEDC_BA98);
    rd_chk(8'h0C, 32'hFEDC_BA98, "R2 filt readback");
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0, "R3 unmapped reads zero");
    rd_chk(8'h00, 32'h00FF_00FF, "R3 unmapped write ignored");

    // Working configuration
    wr(8'h00, 32'h000A_000C);
    wr(8'h04, 32'h0A0A_0505);
    wr(8'h08, 32'h7F1E_14C8);
    wr(8'h0C, 32'h0010_0000);
    rd_chk(8'h00, 32'h000A_000C, "R2 trig readback");
    rd_chk(8'h08, 32'h7F1E_14C8, "R2 selb readback");
    repeat (20) @(negedge clk);
    expect_at(cyc + 1, 8'hFF, 8'h02, "R5 idle state");
    drain();

    // R4 / R5 level channels on pad 5
    @(negedge clk); pad_in[5] = 1'b1; k = cyc;
    expect_at(k + 3, 8'h03, 8'h02, "R4 level not early");
    expect_at(k + 4, 8'h03, 8'h01, "R4 R5 level rise");
    drain();
    repeat (3) @(negedge clk);
    @(negedge clk); pad_in[5] = 1'b0; k = cyc;
    expect_at(k + 3, 8'h03, 8'h01, "R4 level hold");
    expect_at(k + 4, 8'h03, 8'h02, "R4 R5 level fall");
    drain();

    // R6 / R7 edge channels on pad 10
    @(negedge clk); pad_in[10] = 1'b1; k = cyc;
    expect_at(k + 3, 8'h0C, 8'h00, "R6 edge not early");
    expect_at(k + 4, 8'h0C, 8'h04, "R6 R7 rising pulse only");
    expect_at(k + 5, 8'h0C, 8'h00, "R6 pulse one cycle");
    expect_at(k + 8, 8'h0C, 8'h00, "R6 stays low");
    drain();
    @(negedge clk); pad_in[10] = 1'b0; k = cyc;
    expect_at(k + 3, 8'h0C, 8'h00, "R7 edge not early");
    expect_at(k + 4, 8'h0C, 8'h08, "R7 falling pulse only");
    expect_at(k + 5, 8'h0C, 8'h00, "R7 pulse one cycle");
    drain();

    // R9 filter N=1 on channel 5 (window 4)
    @(negedge clk); pad_in[20] = 1'b1; k = cyc;
    for (int i = 1; i <= 12; i++) expect_at(k + i, 8'h20, 8'h00, "R9 short glitch rejected");
    repeat (3) @(negedge clk); pad_in[20] = 1'b0;
    drain();
    @(negedge clk); pad_in[20] = 1'b1; k = cyc;
    expect_at(k + 6, 8'h20, 8'h00, "R9 window not early");
    expect_at(k + 7, 8'h20, 8'h20, "R9 exact window accepted");
    repeat (4) @(negedge clk); pad_in[20] = 1'b0;
    expect_at(k + 10, 8'h20, 8'h20, "R9 release not early");
    expect_at(k + 11, 8'h20, 8'h00, "R9 release accepted");
    drain();

    // R10 highest pad on channel 7, channel 6 undisturbed
    @(negedge clk); pad_in[NP-1] = 1'b1; k = cyc;
    expect_at(k + 4, 8'hC0, 8'h80, "R10 highest pad");
    drain();

    // R8 out-of-range select on channel 4 with every pad high
    @(negedge clk); pad_in = '1; k = cyc;
    expect_at(k + 4, 8'h11, 8'h01, "R8 out of range stays low");
    expect_at(k + 8, 8'h10, 8'h00, "R8 out of range later");
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule